// File: doc/BRIEF.md
# Stepped power-down clock output divider

The block divides a fast clock by a programmable ratio of 1, 2, 4 or 8 and keeps a 50% duty cycle. A power-down request adds a further division by 16. This extra factor is not applied in one jump. It moves by one doubling per reference tick, so the output slows over four steps and speeds back up over four steps. The output never carries a runt pulse.

The divided clock is modelled as a registered logic signal. `clk_i` is taken to run at twice the rate of the clock being divided, so each `clk_i` cycle stands for one half period of that clock. For a total division N, the output therefore stays high for N `clk_i` cycles and then low for N `clk_i` cycles. This makes ÷1 a clean square wave at half the `clk_i` rate.

`ref_tick_i` is a single-cycle pulse in the `clk_i` domain that marks each reference-clock period. `settled_o` tells the surrounding logic when the output has reached its final rate.

Top module: `clk_outdiv_pd`

## Requirements
- R1: With power-down idle and settled, each output high phase and each low phase lasts 2^sel_i clk_i cycles. The select encoding is 00 for ÷1, 01 for ÷2, 10 for ÷4 and 11 for ÷8.
- R2: Every output high phase has the same length as the low phase that follows it, at every ratio and during every transition.
- R3: Once power-down is held and the block has settled, each output phase lasts 16·2^sel_i clk_i cycles.
- R4: The extra divisor moves one doubling per accepted ref_tick_i: 1, 2, 4, 8, 16 while power-down is held and 16, 8, 4, 2, 1 after release. Exactly four accepted ticks take it from one end to the other, and ticks at the target leave it unchanged.
- R5: A ref_tick_i that arrives while the previous step has not yet reached the output is ignored, so no step is skipped.
- R6: If power-down changes mid-sequence, stepping reverses from the current step on the next accepted tick.
- R7: A new select value or step takes effect only at an output rising edge. The phase in progress keeps its old length.
- R8: settled_o is high exactly when the extra divisor is at its target (1 when idle, 16 in power-down), the output already uses that divisor, and it already uses the current sel_i.
- R9: While rst_ni is low the output is low, the extra divisor is 1 and the phase counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the rate of the clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse per reference period, paces the steps |
| sel_i | input | SEL_W | Programmed ratio exponent (ratio = 2^sel_i) |
| pwr_dn_i | input | 1 | Power-down request, adds ÷16 gradually |
| clk_o | output | 1 | Divided clock, registered |
| settled_o | output | 1 | High when the output runs at its final rate |

## Verification
The assertions assume that `ref_tick_i`, `sel_i` and `pwr_dn_i` are synchronous to `clk_i` and that `ref_tick_i` is a pulse. They also assume that select or power-down may change in any cycle, even while a step is pending. The stimulus drives every input on the falling edge of `clk_i` and produces ticks only through a task that raises the pulse for one cycle. Random bursts change select and power-down at arbitrary points and place ticks with random gaps, including gaps shorter than an output period. This exercises the ignored-tick and reversal paths as well as the directed cases.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/pd_stepper.sv
module pd_stepper
  import clkdiv_pkg::*;
#(
  parameter int STEP_MAX = 4,
  localparam int STEP_W = $clog2(STEP_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pd_i,
  input  logic              ack_i,
  output logic [STEP_W-1:0] step_o,
  output logic              at_target_o
);
  localparam logic [STEP_W-1:0] TOP = STEP_W'(STEP_MAX);

  logic [STEP_W-1:0] step_q;
  step_dir_e         dir;

  always_comb begin
    dir = STEP_HOLD;
    if (pd_i && step_q != TOP)       dir = STEP_UP;
    else if (!pd_i && step_q != '0)  dir = STEP_DOWN;
  end

  // advance only after the output has taken the previous step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
    end else if (tick_i && ack_i) begin
      unique case (dir)
        STEP_UP:   step_q <= step_q + 1'b1;
        STEP_DOWN: step_q <= step_q - 1'b1;
        default:   step_q <= step_q;
      endcase
    end
  end

  assign step_o      = step_q;
  assign at_target_o = (dir == STEP_HOLD);
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int SEL_W  = 2,
  parameter int STEP_W = 3,
  parameter int EXP_W  = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              clk_o,
  output logic [SEL_W-1:0]  act_sel_o,
  output logic [STEP_W-1:0] act_step_o,
  output logic [EXP_W-1:0]  act_exp_o
);
  logic [SEL_W-1:0]  act_sel_q;
  logic [STEP_W-1:0] act_step_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              out_q;
  logic [EXP_W-1:0]  act_exp;
  logic [CNT_W-1:0]  half_last;
  logic              phase_end;

  assign act_exp   = EXP_W'(act_sel_q) + EXP_W'(act_step_q);
  assign half_last = (CNT_W'(1) << act_exp) - CNT_W'(1);
  assign phase_end = (cnt_q == half_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q      <= 1'b0;
      cnt_q      <= '0;
      act_sel_q  <= '0;
      act_step_q <= '0;
    end else if (phase_end) begin
      out_q <= ~out_q;
      cnt_q <= '0;
      // new ratio only at a rising edge: both halves of a period match
      if (!out_q) begin
        act_sel_q  <= sel_i;
        act_step_q <= step_i;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o      = out_q;
  assign act_sel_o  = act_sel_q;
  assign act_step_o = act_step_q;
  assign act_exp_o  = act_exp;
endmodule

// File: rtl/clk_outdiv_pd.sv
module clk_outdiv_pd #(
  parameter int SEL_W   = 2,
  parameter int PD_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pwr_dn_i,
  output logic             clk_o,
  output logic             settled_o
);
  localparam int STEP_W  = $clog2(PD_LOG2 + 1);
  localparam int MAX_EXP = (2 ** SEL_W - 1) + PD_LOG2;
  localparam int EXP_W   = $clog2(MAX_EXP + 1);
  localparam int CNT_W   = MAX_EXP + 1;

  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] act_step;
  logic [SEL_W-1:0]  act_sel;
  logic [EXP_W-1:0]  act_exp;
  logic              step_ack;
  logic              at_target;

  assign step_ack = (act_step == step);

  pd_stepper #(.STEP_MAX(PD_LOG2)) u_stepper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ref_tick_i),
    .pd_i       (pwr_dn_i),
    .ack_i      (step_ack),
    .step_o     (step),
    .at_target_o(at_target)
  );

  div_core #(
    .SEL_W (SEL_W),
    .STEP_W(STEP_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .step_i    (step),
    .clk_o     (clk_o),
    .act_sel_o (act_sel),
    .act_step_o(act_step),
    .act_exp_o (act_exp)
  );

  assign settled_o = at_target && step_ack && (act_sel == sel_i);
endmodule

// File: rtl/clk_outdiv_pd_chk.sv
module clk_outdiv_pd_chk #(
  parameter int STEP_W  = 3,
  parameter int EXP_W   = 3,
  parameter int PD_LOG2 = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_tick_i,
  input logic              clk_o,
  input logic [STEP_W-1:0] step,
  input logic [STEP_W-1:0] act_step,
  input logic [EXP_W-1:0]  act_exp
);
  localparam int RUN_W = (1 << EXP_W) + 2;

  logic             prev_out;
  logic             seen;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_out <= 1'b0;
      seen     <= 1'b0;
      run      <= '0;
    end else begin
      prev_out <= clk_o;
      if (clk_o != prev_out) begin
        run  <= RUN_W'(1);
        seen <= 1'b1;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  a_r4_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step <= STEP_W'(PD_LOG2));

  a_r4_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step != $past(step)) |->
      (step == $past(step) + 1'b1 || step + 1'b1 == $past(step)));

  a_r4_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_tick_i |=> $stable(step));

  a_r5_wait_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_tick_i && act_step != step) |=> $stable(step));

  a_r7_change_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_exp != $past(act_exp)) |-> (clk_o && !$past(clk_o)));

  a_r2_phase_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && clk_o != $past(clk_o)) |->
      (run == (RUN_W'(1) << $past(act_exp))));
endmodule

bind clk_outdiv_pd clk_outdiv_pd_chk #(
  .STEP_W (STEP_W),
  .EXP_W  (EXP_W),
  .PD_LOG2(PD_LOG2)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_tick_i(ref_tick_i),
  .clk_o     (clk_o),
  .step      (step),
  .act_step  (act_step),
  .act_exp   (act_exp)
);

// File: tb/clk_outdiv_pd_tb.sv
module clk_outdiv_pd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       pd = 1'b0;
  logic       clk_o;
  logic       settled;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int mon_bad = 0;
  int mon_periods = 0;
  int mon_run = 0;
  int mon_hi = 0;
  bit mon_lvl = 1'b0;
  bit mon_have_hi = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clk_outdiv_pd u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_tick_i(ref_tick),
    .sel_i     (sel),
    .pwr_dn_i  (pd),
    .clk_o     (clk_o),
    .settled_o (settled)
  );

  function automatic int half_exp(input int s, input int k);
    return (1 << s) << k;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0) && (v <= 128);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // whole-run monitor: each high phase must equal the low phase after it (R2, R7)
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_run = 0;
      mon_lvl = 1'b0;
      mon_have_hi = 1'b0;
    end else if (clk_o == mon_lvl) begin
      mon_run++;
    end else begin
      if (mon_lvl) begin
        mon_hi = mon_run;
        mon_have_hi = 1'b1;
      end else if (mon_have_hi) begin
        mon_periods++;
        if (mon_hi != mon_run || !is_pow2(mon_run)) mon_bad++;
      end
      mon_run = 1;
      mon_lvl = clk_o;
    end
  end

  task automatic tick();
    @(negedge clk) ref_tick = 1'b1;
    @(negedge clk) ref_tick = 1'b0;
  endtask

  task automatic measure(output int h, output int l);
    h = 0;
    l = 0;
    @(negedge clk);
    while (clk_o !== 1'b0) @(negedge clk);
    while (clk_o !== 1'b1) @(negedge clk);
    while (clk_o === 1'b1) begin h++; @(negedge clk); end
    while (clk_o === 1'b0) begin l++; @(negedge clk); end
  endtask

  task automatic check_ratio(input string req, input int exp);
    int h;
    int l;
    measure(h, l);
    chk(h == exp, req, h, exp);
    chk(l == exp, req, l, exp);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h;
    int l;
    void'($urandom(32'd4242));

    // R9: reset state
    repeat (4) @(negedge clk);
    chk(clk_o == 1'b0, "R9 out low in reset", int'(clk_o), 0);
    chk(settled == 1'b1, "R8 settled in reset", int'(settled), 1);
    rst_n = 1'b1;

    // R1: all select codes
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      check_ratio("R1", half_exp(s, 0));
      chk(settled == 1'b1, "R8 settled after sel", int'(settled), 1);
    end

    // R3/R4: four steps down, then four back up
    sel = 2'd2;
    check_ratio("R1", half_exp(2, 0));
    pd = 1'b1;
    @(negedge clk);
    chk(settled == 1'b0, "R8 not settled on request", int'(settled), 0);
    for (int k = 1; k <= 4; k++) begin
      tick();
      check_ratio("R4 power-down step", half_exp(2, k));
      if (k < 4) chk(settled == 1'b0, "R8 mid sequence", int'(settled), 0);
    end
    chk(settled == 1'b1, "R3 settled at 16", int'(settled), 1);
    tick();
    check_ratio("R3 held at 16", half_exp(2, 4));
    pd = 1'b0;
    for (int k = 3; k >= 0; k--) begin
      tick();
      check_ratio("R4 release step", half_exp(2, k));
    end
    chk(settled == 1'b1, "R4 four release steps", int'(settled), 1);

    // R6: reversal mid sequence
    pd = 1'b1;
    tick(); check_ratio("R6 up", half_exp(2, 1));
    tick(); check_ratio("R6 up", half_exp(2, 2));
    pd = 1'b0;
    tick(); check_ratio("R6 reversed down", half_exp(2, 1));
    pd = 1'b1;
    tick(); check_ratio("R6 reversed up", half_exp(2, 2));
    pd = 1'b0;
    tick(); check_ratio("R6", half_exp(2, 1));
    tick(); check_ratio("R6", half_exp(2, 0));

    // R5: back-to-back ticks just after a rise, only one accepted
    sel = 2'd3;
    check_ratio("R1", half_exp(3, 0));
    pd = 1'b1;
    @(negedge clk);
    while (clk_o !== 1'b0) @(negedge clk);
    while (clk_o !== 1'b1) @(negedge clk);
    ref_tick = 1'b1;
    repeat (3) @(negedge clk);
    ref_tick = 1'b0;
    check_ratio("R5 pending ticks ignored", half_exp(3, 1));
    check_ratio("R5 no skipped step", half_exp(3, 1));
    pd = 1'b0;
    tick(); check_ratio("R5", half_exp(3, 0));

    // R7: select change inside a high phase keeps the running period
    @(negedge clk);
    while (clk_o !== 1'b0) @(negedge clk);
    while (clk_o !== 1'b1) @(negedge clk);
    sel = 2'd0;
    h = 1;
    @(negedge clk);
    while (clk_o === 1'b1) begin h++; @(negedge clk); end
    l = 0;
    while (clk_o === 1'b0) begin l++; @(negedge clk); end
    chk(h == 8, "R7 high kept", h, 8);
    chk(l == 8, "R7 low kept", l, 8);
    check_ratio("R7 new ratio next period", half_exp(0, 0));

    // random mix
    for (int it = 0; it < 24; it++) begin
      int n_b;
      sel = 2'($urandom % 4);
      pd = 1'($urandom % 2);
      n_b = $urandom_range(1, 6);
      for (int b = 0; b < n_b; b++) begin
        tick();
        if ($urandom % 4 == 0) pd = ~pd;
        if ($urandom % 5 == 0) sel = 2'($urandom % 4);
        repeat ($urandom_range(0, 40)) @(negedge clk);
      end
      for (int g = 0; g < 8 && !settled; g++) begin
        tick();
        repeat (300) @(negedge clk);
      end
      chk(settled == 1'b1, "R8 random settles", int'(settled), 1);
      check_ratio(pd ? "R3 random" : "R1 random", half_exp(int'(sel), pd ? 4 : 0));
    end

    chk(mon_bad == 0, "R2 duty every period", mon_bad, 0);
    chk(mon_periods > 100, "R7 glitch-free periods seen", mon_periods, 101);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule